// File: doc/BRIEF.md
# Pin Bank with Peripheral Override Control

This block is a parameterized bank of general-purpose I/O pins. Software sets, for each pin, a direction bit and an output bit, plus one bank-wide bit that turns off all the automatic pull-ups. A simple address/data bus reads and writes these registers. From that state the block works out four values for each pin: the pull-up enable, the output driver enable, the driven level and the digital input enable.

Peripherals can take over any of those four values, one pin at a time. Each takeover uses an enable/value pair. A peripheral can also send a one-cycle toggle pulse that inverts the stored output bit.

The pad is modelled as separate input, output, output-enable, pull-up and input-enable signals. The block passes two views of the pad input. Peripherals get a gated copy with no synchronizer, and they must synchronize it themselves. Software reads a copy that has gone through a flop synchronizer.

Top module: `pinbank_ovr`

## Requirements
- R1: When `ovr_pu_en` is 0 and the pin is not driven, `pad_pu` is 1 only when the direction bit is 0, the output bit is 1 and the bank pull-up disable bit is 0. Any other combination gives 0.
- R2: When `ovr_pu_en` is 1 and the pin is not driven, `pad_pu` equals `ovr_pu_val`, whatever the register bits hold.
- R3: `pad_pu` is 0 in every cycle in which `pad_oe` is 1.
- R4: `pad_oe` equals `ovr_dd_val` when `ovr_dd_en` is 1. Otherwise it equals the direction bit.
- R5: When `pad_oe` is 1, `pad_out` equals `ovr_pv_val` if `ovr_pv_en` is 1, and the stored output bit if it is 0. When `pad_oe` is 0, `pad_out` is 0.
- R6: Each clock edge at which `ovr_tgl` is 1 inverts the stored output bit exactly once. The new value can be read at address 1 after that edge.
- R7: A bus write to address 1 at the same edge as a toggle pulse stores the written data, and the toggle is dropped.
- R8: `pad_ie` equals `ovr_die_val` when `ovr_die_en` is 1. Otherwise it equals the inverse of `sleep_i`.
- R9: `din_raw` equals `pad_in` AND `pad_ie`, with no register in the path.
- R10: A read at address 2 returns `din_raw` delayed by exactly two clock edges. A pin whose input is disabled therefore reads 0.
- R11: After reset the direction bits, output bits and pull-up disable bit are all 0.
- R12: The register map is fixed:
  - address 0 is the direction bits, where 1 means output;
  - address 1 is the output bits;
  - address 2 is the read-only pin value, and writes to it change nothing;
  - address 3 holds the pull-up disable in bit 0, with all other bits reading 0.
  
  `bus_rdata` is combinational from `bus_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | N_PINS | Write data |
| bus_rdata | output | N_PINS | Read data |
| sleep_i | input | 1 | Device sleep state; gates digital inputs |
| ovr_pu_en | input | N_PINS | Pull-up override enable |
| ovr_pu_val | input | N_PINS | Pull-up override value |
| ovr_dd_en | input | N_PINS | Direction override enable |
| ovr_dd_val | input | N_PINS | Direction override value |
| ovr_pv_en | input | N_PINS | Driven-value override enable |
| ovr_pv_val | input | N_PINS | Driven-value override value |
| ovr_tgl | input | N_PINS | Output-bit toggle pulse |
| ovr_die_en | input | N_PINS | Input-enable override enable |
| ovr_die_val | input | N_PINS | Input-enable override value |
| pad_in | input | N_PINS | Level seen at each pad |
| pad_out | output | N_PINS | Level driven to each pad |
| pad_oe | output | N_PINS | Output driver enable |
| pad_pu | output | N_PINS | Pull-up enable |
| pad_ie | output | N_PINS | Digital input enable |
| din_raw | output | N_PINS | Gated, unsynchronized input for peripherals |

## Verification
Two updates to the stored output bit can land on the same clock edge: a peripheral toggle pulse and a software write to address 1.

The random phase raises both strobes often, so they overlap in many cycles. A directed case then writes a known pattern under an all-ones toggle.

A bench model applies the write-wins rule, and the readback at address 1 on the next cycle is compared against it. A second overlap is also judged every cycle: a sleep or input-enable override change against the pin-read synchronizer, using the two-edge delay.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
   typedef enum logic [1:0] {
      SEL_DIR = 2'd0,
      SEL_OUT = 2'd1,
      SEL_PIN = 2'd2,
      SEL_CTL = 2'd3
   } pin_reg_sel_e;

   localparam int unsigned PIN_REG_COUNT = 4;
   localparam int unsigned CTL_PUD_BIT   = 0;
endpackage

// File: rtl/pinbank_regs.sv
module pinbank_regs
   import pinbank_pkg::*;
#(
   parameter int unsigned N_PINS = 8,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [N_PINS-1:0] wdata,
   input  logic [N_PINS-1:0] tgl,
   input  logic [N_PINS-1:0] pin_q,
   output logic [N_PINS-1:0] dir_q,
   output logic [N_PINS-1:0] out_q,
   output logic              pud_q,
   output logic [N_PINS-1:0] rdata
);
   localparam int unsigned SEL_W = 2;

   logic              in_map;
   logic [SEL_W-1:0]  sel;
   logic              wr_dir, wr_out, wr_ctl;

   if (ADDR_W > SEL_W) begin : g_hi_dec
      assign in_map = (addr[ADDR_W-1:SEL_W] == '0);
   end else begin : g_no_hi
      assign in_map = 1'b1;
   end
   assign sel = addr[SEL_W-1:0];

   assign wr_dir = we && in_map && (sel == SEL_DIR);
   assign wr_out = we && in_map && (sel == SEL_OUT);
   assign wr_ctl = we && in_map && (sel == SEL_CTL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
      end else if (wr_dir) begin
         dir_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
      end else if (wr_out) begin
         out_q <= wdata;
      end else begin
         out_q <= out_q ^ tgl;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pud_q <= 1'b0;
      end else if (wr_ctl) begin
         pud_q <= wdata[CTL_PUD_BIT];
      end
   end

   always_comb begin
      rdata = '0;
      if (in_map) begin
         unique case (sel)
            SEL_DIR: rdata = dir_q;
            SEL_OUT: rdata = out_q;
            SEL_PIN: rdata = pin_q;
            default: rdata[CTL_PUD_BIT] = pud_q;
         endcase
      end
   end

   // R7: write beats a coincident toggle
   a_r7_write_wins : assert property (@(posedge clk) disable iff (!rst_n)
      wr_out |=> (out_q == $past(wdata)));

   // R6: each toggle pulse flips the stored bit once
   a_r6_toggle_flip : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_out |=> (out_q == ($past(out_q) ^ $past(tgl))));
endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
   parameter int unsigned N_PINS = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] d,
   output logic [N_PINS-1:0] q
);
   logic [STAGES-1:0][N_PINS-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= '0;
         end else begin
            chain[s] <= (s == 0) ? d : chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pinbank_pinctl.sv
module pinbank_pinctl (
   input  logic dir,
   input  logic outb,
   input  logic pud,
   input  logic sleep,
   input  logic pu_en,
   input  logic pu_val,
   input  logic dd_en,
   input  logic dd_val,
   input  logic pv_en,
   input  logic pv_val,
   input  logic die_en,
   input  logic die_val,
   input  logic pin,
   output logic oe,
   output logic dout,
   output logic pu,
   output logic ie,
   output logic din
);
   logic pu_auto;
   logic pu_sel;
   logic lvl;

   assign oe      = dd_en ? dd_val : dir;
   assign pu_auto = ~dir & outb & ~pud;
   assign pu_sel  = pu_en ? pu_val : pu_auto;
   assign pu      = pu_sel & ~oe;
   assign lvl     = pv_en ? pv_val : outb;
   assign dout    = oe & lvl;
   assign ie      = die_en ? die_val : ~sleep;
   assign din     = pin & ie;
endmodule

// File: rtl/pinbank_ovr.sv
module pinbank_ovr
   import pinbank_pkg::*;
#(
   parameter int unsigned N_PINS      = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [N_PINS-1:0] bus_wdata,
   output logic [N_PINS-1:0] bus_rdata,
   input  logic              sleep_i,
   input  logic [N_PINS-1:0] ovr_pu_en,
   input  logic [N_PINS-1:0] ovr_pu_val,
   input  logic [N_PINS-1:0] ovr_dd_en,
   input  logic [N_PINS-1:0] ovr_dd_val,
   input  logic [N_PINS-1:0] ovr_pv_en,
   input  logic [N_PINS-1:0] ovr_pv_val,
   input  logic [N_PINS-1:0] ovr_tgl,
   input  logic [N_PINS-1:0] ovr_die_en,
   input  logic [N_PINS-1:0] ovr_die_val,
   input  logic [N_PINS-1:0] pad_in,
   output logic [N_PINS-1:0] pad_out,
   output logic [N_PINS-1:0] pad_oe,
   output logic [N_PINS-1:0] pad_pu,
   output logic [N_PINS-1:0] pad_ie,
   output logic [N_PINS-1:0] din_raw
);
   localparam int unsigned MIN_ADDR_W = $clog2(PIN_REG_COUNT);

   if (N_PINS < 1) begin : g_bad_pins
      $error("pinbank_ovr: N_PINS must be at least 1");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("pinbank_ovr: ADDR_W too narrow for the register map");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pinbank_ovr: SYNC_STAGES must be at least 2");
   end

   logic [N_PINS-1:0] dir_q, out_q, pin_q;
   logic              pud_q;

   pinbank_regs #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) regs_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bus_we),
      .addr  (bus_addr),
      .wdata (bus_wdata),
      .tgl   (ovr_tgl),
      .pin_q (pin_q),
      .dir_q (dir_q),
      .out_q (out_q),
      .pud_q (pud_q),
      .rdata (bus_rdata)
   );

   for (genvar i = 0; i < N_PINS; i++) begin : g_pin
      pinbank_pinctl ctl_i (
         .dir     (dir_q[i]),
         .outb    (out_q[i]),
         .pud     (pud_q),
         .sleep   (sleep_i),
         .pu_en   (ovr_pu_en[i]),
         .pu_val  (ovr_pu_val[i]),
         .dd_en   (ovr_dd_en[i]),
         .dd_val  (ovr_dd_val[i]),
         .pv_en   (ovr_pv_en[i]),
         .pv_val  (ovr_pv_val[i]),
         .die_en  (ovr_die_en[i]),
         .die_val (ovr_die_val[i]),
         .pin     (pad_in[i]),
         .oe      (pad_oe[i]),
         .dout    (pad_out[i]),
         .pu      (pad_pu[i]),
         .ie      (pad_ie[i]),
         .din     (din_raw[i])
      );

      // R4: driver enable follows the direction register when not overridden
      a_r4_oe_from_dir : assert property (@(posedge clk) disable iff (!rst_n)
         !ovr_dd_en[i] |-> (pad_oe[i] == dir_q[i]));

      // R1: automatic pull-up rule from stored state
      a_r1_auto_pullup : assert property (@(posedge clk) disable iff (!rst_n)
         (!ovr_pu_en[i] && !pad_oe[i]) |->
            (pad_pu[i] == (!dir_q[i] && out_q[i] && !pud_q)));
   end

   pinbank_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (din_raw),
      .q     (pin_q)
   );

   if (SYNC_STAGES == 2) begin : g_lat_chk
      logic [1:0] warm;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            warm <= '0;
         end else if (warm != 2'd3) begin
            warm <= warm + 2'd1;
         end
      end

      // R10: pin readback is the raw input two edges later
      a_r10_sync_latency : assert property (@(posedge clk) disable iff (!rst_n)
         (warm >= 2'd2) |-> (pin_q == $past(din_raw, 2)));
   end
endmodule

// File: tb/pinbank_ovr_tb.sv
module pinbank_ovr_tb_top;
   localparam int N  = 8;
   localparam int AW = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          bus_we;
   logic [AW-1:0] bus_addr;
   logic [N-1:0]  bus_wdata, bus_rdata;
   logic          sleep_i;
   logic [N-1:0]  ovr_pu_en, ovr_pu_val, ovr_dd_en, ovr_dd_val;
   logic [N-1:0]  ovr_pv_en, ovr_pv_val, ovr_tgl, ovr_die_en, ovr_die_val;
   logic [N-1:0]  pad_in, pad_out, pad_oe, pad_pu, pad_ie, din_raw;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   logic [N-1:0] m_dir, m_out, m_s1, m_s2;
   logic         m_pud;

   always #4 clk = ~clk;

   pinbank_ovr #(.N_PINS(N), .ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_i(sleep_i),
      .ovr_pu_en(ovr_pu_en), .ovr_pu_val(ovr_pu_val),
      .ovr_dd_en(ovr_dd_en), .ovr_dd_val(ovr_dd_val),
      .ovr_pv_en(ovr_pv_en), .ovr_pv_val(ovr_pv_val),
      .ovr_tgl(ovr_tgl), .ovr_die_en(ovr_die_en), .ovr_die_val(ovr_die_val),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .pad_pu(pad_pu), .pad_ie(pad_ie), .din_raw(din_raw)
   );

   function automatic logic [N-1:0] f_oe();
      return (ovr_dd_en & ovr_dd_val) | (~ovr_dd_en & m_dir);
   endfunction

   function automatic logic [N-1:0] f_pu();
      logic [N-1:0] autop;
      autop = ~m_dir & m_out & {N{~m_pud}};
      return ((ovr_pu_en & ovr_pu_val) | (~ovr_pu_en & autop)) & ~f_oe();
   endfunction

   function automatic logic [N-1:0] f_out();
      return f_oe() & ((ovr_pv_en & ovr_pv_val) | (~ovr_pv_en & m_out));
   endfunction

   function automatic logic [N-1:0] f_ie();
      return (ovr_die_en & ovr_die_val) | (~ovr_die_en & {N{~sleep_i}});
   endfunction

   function automatic logic [N-1:0] f_rd();
      logic [N-1:0] r;
      r = '0;
      case (bus_addr)
         2'd0: r = m_dir;
         2'd1: r = m_out;
         2'd2: r = m_s2;
         default: r[0] = m_pud;
      endcase
      return r;
   endfunction

   task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      bus_we = 0; bus_addr = '0; bus_wdata = '0; sleep_i = 0;
      ovr_pu_en = '0; ovr_pu_val = '0; ovr_dd_en = '0; ovr_dd_val = '0;
      ovr_pv_en = '0; ovr_pv_val = '0; ovr_tgl = '0;
      ovr_die_en = '0; ovr_die_val = '0; pad_in = '0;
   endtask

   // inputs already driven after a falling edge; check, advance model, wait
   task automatic cycle();
      logic [N-1:0] din_e;
      #1;
      chk("R4 driver enable", pad_oe, f_oe());
      chk("R1/R2/R3 pull-up", pad_pu, f_pu());
      chk("R5 driven value", pad_out, f_out());
      chk("R8 input enable", pad_ie, f_ie());
      din_e = pad_in & f_ie();
      chk("R9 raw input", din_raw, din_e);
      chk("R6/R7/R10/R11/R12 readback", bus_rdata, f_rd());
      if (bus_we && bus_addr == 2'd0) m_dir = bus_wdata;
      if (bus_we && bus_addr == 2'd1) m_out = bus_wdata;
      else m_out = m_out ^ ovr_tgl;
      if (bus_we && bus_addr == 2'd3) m_pud = bus_wdata[0];
      m_s2 = m_s1;
      m_s1 = din_e;
      @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
      bus_we = 1; bus_addr = a; bus_wdata = d;
      cycle();
      bus_we = 0;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      idle_inputs();
      rst_n = 0;
      m_dir = '0; m_out = '0; m_pud = 0; m_s1 = '0; m_s2 = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R11: reset values
      bus_addr = 2'd0; #1 chk("R11 dir reset", bus_rdata, '0);
      bus_addr = 2'd1; #1 chk("R11 out reset", bus_rdata, '0);
      bus_addr = 2'd3; #1 chk("R11 pud reset", bus_rdata, '0);
      chk("R11 no drive", pad_oe, '0);
      cycle();

      // R1: automatic pull-up on input pins with output bit set
      wr(2'd1, 8'hA5);
      wr(2'd0, 8'h0F);
      #1 chk("R1 auto pull-up", pad_pu, 8'hA0);
      cycle();
      wr(2'd3, 8'h01);
      #1 chk("R1 disabled by pud", pad_pu, 8'h00);
      cycle();

      // R7: write and toggle in the same cycle
      wr(2'd1, 8'hF0);
      ovr_tgl = 8'hFF;
      wr(2'd1, 8'h3C);
      ovr_tgl = '0;
      bus_addr = 2'd1;
      #1 chk("R7 write beats toggle", bus_rdata, 8'h3C);
      cycle();

      // R6: single toggle pulse
      ovr_tgl = 8'h81;
      cycle();
      ovr_tgl = '0; bus_addr = 2'd1;
      #1 chk("R6 single flip", bus_rdata, 8'hBD);
      cycle();

      // R12: write to pin register changes nothing
      wr(2'd2, 8'h55);
      bus_addr = 2'd0;
      #1 chk("R12 dir untouched", bus_rdata, 8'h0F);
      cycle();

      // R10: sleep gates input, readback after two edges
      pad_in = 8'hFF; sleep_i = 1; bus_addr = 2'd2;
      cycle(); cycle();
      #1 chk("R10 disabled pin reads 0", bus_rdata, 8'h00);
      cycle();
      sleep_i = 0;
      cycle(); cycle();
      #1 chk("R10 enabled pin reads 1", bus_rdata, 8'hFF);
      cycle();

      // random phase
      for (int k = 0; k < 3000; k++) begin
         bus_we      = ($urandom % 4) == 0;
         bus_addr    = AW'($urandom);
         bus_wdata   = N'($urandom);
         sleep_i     = ($urandom % 3) == 0;
         ovr_pu_en   = N'($urandom); ovr_pu_val  = N'($urandom);
         ovr_dd_en   = N'($urandom) & N'($urandom);
         ovr_dd_val  = N'($urandom);
         ovr_pv_en   = N'($urandom); ovr_pv_val  = N'($urandom);
         ovr_tgl     = N'($urandom) & N'($urandom);
         ovr_die_en  = N'($urandom) & N'($urandom);
         ovr_die_val = N'($urandom);
         pad_in      = N'($urandom);
         cycle();
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule